// File: doc/BRIEF.md
# Masked Vector Load/Store Sequencer

This block carries out one conditional packed transfer between a vector of up to 256 bits and memory. A start pulse captures the operation kind (load or store), the element width (32 or 64 bits), the vector length (128 or 256 bits), a base byte address, a mask vector and the store data. Each element position of the mask holds an enable in its top bit. Only enabled lanes touch memory, one request at a time, over a request/acknowledge port that can flag a fault.

On a load, enabled lanes receive memory data and every other lane reads as zero. A 128-bit load also clears everything above bit 127. The assembled value is published only when all enabled lanes have completed cleanly. On a store, enabled lanes write their element and disabled lanes leave memory alone. When an acknowledge comes back with the fault flag, the sequence stops. The block then reports the faulting lane together with its completion pulse.

Top module: `mvls_unit`

## Requirements
- R1: The enable for lane i is bit 32*i+31 of the mask for 32-bit elements, or bit 64*i+63 for 64-bit elements. Only lanes below the lane count are considered: 4 or 8 lanes of 32 bits, 2 or 4 lanes of 64 bits, for a 128- or 256-bit vector. All other mask bits have no effect.
- R2: The request for lane i carries the address base + 4*i (32-bit) or base + 8*i (64-bit). mem_size is 0 for 32-bit and 1 for 64-bit elements.
- R3: On a successful load, lane i of load_data equals mem_rdata[31:0] (32-bit) or mem_rdata[63:0] (64-bit) if enabled, and zero if disabled. With vec256=0, load_data[255:128] is zero.
- R4: A store issues exactly one request with mem_we=1 per enabled lane. mem_wdata is the lane element (32-bit elements zero-extended to 64 bits). A disabled lane issues no request, and its memory stays unchanged.
- R5: Enabled lanes are issued in ascending lane order with at most one request outstanding. mem_req, mem_addr, mem_we and mem_wdata stay stable until mem_ack.
- R6: An all-zero effective mask completes with done, no request and fault=0.
- R7: An acknowledge with mem_fault=1 stops all further requests. The block then pulses done with fault=1 and fault_lane set to that lane's index, and load_data keeps its previous value.
- R8: done is a one-cycle pulse. A start pulse while an operation is in progress (including the cycle of the last acknowledge) is ignored. A start in the done cycle begins a new operation.
- R9: load_data changes only at the done pulse of a load that completed without a fault. Inputs other than start are sampled only on an accepted start.

Ports in order of the port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_store | input | 1 | 0 = load, 1 = store |
| elem64 | input | 1 | 0 = 32-bit elements, 1 = 64-bit elements |
| vec256 | input | 1 | 0 = 128-bit vector, 1 = 256-bit vector |
| base_addr | input | 32 | Byte address of lane 0 |
| mask | input | 256 | Mask vector; lane enables in element top bits |
| store_data | input | 256 | Register data for a store |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_size | output | 1 | 0 = 32-bit access, 1 = 64-bit access |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| mem_fault | input | 1 | Access faulted, valid with mem_ack |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation ended on a fault |
| fault_lane | output | 3 | Index of the faulting lane |
| load_data | output | 256 | Committed load result |

## Verification
A start pulse can arrive in the same cycle as the memory acknowledge that completes the final lane. In that cycle the sequencer is still busy, so the pulse must be dropped. The bench drives start in exactly that cycle, after changing the mask to all ones, and then judges by watching the request port go quiet for several cycles after done. It also drives start in the done cycle itself, where the pulse must be taken. That case is judged by counting one fresh request per lane of the new operation.

// File: rtl/mvls_pkg.sv
package mvls_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_e;

    typedef enum logic {
        ES_32 = 1'b0,
        ES_64 = 1'b1
    } esz_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_WAIT = 2'd2
    } state_e;

    typedef struct packed {
        op_e  op;
        esz_e es;
        logic wide;
    } ctx_t;

    localparam int unsigned DW_BITS = 32;
    localparam int unsigned QW_BITS = 64;

    function automatic int unsigned dw_lanes(input int unsigned vec_w);
        return vec_w / DW_BITS;
    endfunction

endpackage

// File: rtl/mvls_lane_sel.sv
module mvls_lane_sel
    import mvls_pkg::*;
#(
    parameter int unsigned VEC_W = 256,
    localparam int unsigned LANES = dw_lanes(VEC_W),
    localparam int unsigned QL = LANES / 2
) (
    input  logic [VEC_W-1:0] mask,
    input  ctx_t             ctx,
    output logic [LANES-1:0] en
);

    logic [LANES-1:0] dw_en;
    logic [QL-1:0]    qw_en;

    for (genvar i = 0; i < LANES; i++) begin : g_dw
        localparam logic IN_LOW = (i < LANES / 2);
        assign dw_en[i] = mask[DW_BITS*i + DW_BITS - 1] & (ctx.wide | IN_LOW);
    end

    for (genvar q = 0; q < QL; q++) begin : g_qw
        localparam logic IN_LOW = (q < QL / 2);
        assign qw_en[q] = mask[QW_BITS*q + QW_BITS - 1] & (ctx.wide | IN_LOW);
    end

    always_comb begin
        if (ctx.es == ES_64) en = {{(LANES-QL){1'b0}}, qw_en};
        else                 en = dw_en;
    end

endmodule

// File: rtl/mvls_lane_pick.sv
module mvls_lane_pick #(
    parameter int unsigned LANES = 8,
    localparam int unsigned IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = |pend;
        idx   = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mvls_ctrl.sv
module mvls_ctrl
    import mvls_pkg::*;
#(
    parameter int unsigned VEC_W = 256,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned LANES = dw_lanes(VEC_W),
    localparam int unsigned IDX_W = $clog2(LANES),
    localparam int unsigned MEM_W = QW_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ctx_t              ctx_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [LANES-1:0]  en_in,
    input  logic [VEC_W-1:0]  sdata_in,
    input  logic              pick_found,
    input  logic [IDX_W-1:0]  pick_idx,
    output logic [LANES-1:0]  pend,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [MEM_W-1:0]  mem_wdata,
    output logic              mem_size,
    input  logic              mem_ack,
    input  logic [MEM_W-1:0]  mem_rdata,
    input  logic              mem_fault,
    output logic              done,
    output logic              fault,
    output logic [IDX_W-1:0]  fault_lane,
    output logic [VEC_W-1:0]  load_data
);

    state_e            state_q;
    ctx_t              ctx_q;
    logic [ADDR_W-1:0] base_q;
    logic [VEC_W-1:0]  sdata_q;
    logic [LANES-1:0]  pend_q;
    logic [IDX_W-1:0]  lane_q;
    logic              req_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [MEM_W-1:0]  wdata_q;
    logic              size_q;
    logic [VEC_W-1:0]  shadow_q;
    logic [VEC_W-1:0]  result_q;
    logic              done_q;
    logic              fault_q;
    logic [IDX_W-1:0]  flane_q;

    logic [ADDR_W-1:0] nxt_addr;
    logic [MEM_W-1:0]  nxt_wdata;

    always_comb begin
        if (ctx_q.es == ES_64) begin
            nxt_addr  = base_q + (ADDR_W'(pick_idx) << 3);
            nxt_wdata = sdata_q[int'(pick_idx[IDX_W-2:0])*QW_BITS +: QW_BITS];
        end else begin
            nxt_addr  = base_q + (ADDR_W'(pick_idx) << 2);
            nxt_wdata = MEM_W'(sdata_q[int'(pick_idx)*DW_BITS +: DW_BITS]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ctx_q    <= '0;
            base_q   <= '0;
            sdata_q  <= '0;
            pend_q   <= '0;
            lane_q   <= '0;
            req_q    <= 1'b0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            size_q   <= 1'b0;
            shadow_q <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            flane_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctx_q    <= ctx_in;
                        base_q   <= base_in;
                        sdata_q  <= sdata_in;
                        pend_q   <= en_in;
                        shadow_q <= '0;
                        fault_q  <= 1'b0;
                        state_q  <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (pick_found) begin
                        req_q   <= 1'b1;
                        we_q    <= (ctx_q.op == OP_STORE);
                        addr_q  <= nxt_addr;
                        wdata_q <= nxt_wdata;
                        size_q  <= (ctx_q.es == ES_64);
                        lane_q  <= pick_idx;
                        state_q <= ST_WAIT;
                    end else begin
                        done_q  <= 1'b1;
                        if (ctx_q.op == OP_LOAD) result_q <= shadow_q;
                        state_q <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (mem_ack) begin
                        req_q <= 1'b0;
                        if (mem_fault) begin
                            fault_q <= 1'b1;
                            flane_q <= lane_q;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            pend_q[lane_q] <= 1'b0;
                            if (ctx_q.op == OP_LOAD) begin
                                if (ctx_q.es == ES_64)
                                    shadow_q[int'(lane_q[IDX_W-2:0])*QW_BITS +: QW_BITS] <= mem_rdata;
                                else
                                    shadow_q[int'(lane_q)*DW_BITS +: DW_BITS] <= mem_rdata[DW_BITS-1:0];
                            end
                            state_q <= ST_PICK;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign pend       = pend_q;
    assign mem_req    = req_q;
    assign mem_we     = we_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;
    assign mem_size   = size_q;
    assign done       = done_q;
    assign fault      = fault_q;
    assign fault_lane = flane_q;
    assign load_data  = result_q;

    // Checker state: enables captured at start, last completed lane.
    logic [LANES-1:0] en_snap_q;
    logic [IDX_W-1:0] prev_lane_q;
    logic             have_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_snap_q   <= '0;
            prev_lane_q <= '0;
            have_prev_q <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            en_snap_q   <= en_in;
            have_prev_q <= 1'b0;
        end else if (mem_req && mem_ack && !mem_fault) begin
            prev_lane_q <= lane_q;
            have_prev_q <= 1'b1;
        end
    end

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

    assert_ascending_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && have_prev_q |-> lane_q > prev_lane_q);

    assert_req_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> en_snap_q[lane_q]);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_fault_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> !mem_req && $stable(load_data) && en_snap_q[fault_lane]);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_IDLE && start |=> $stable(ctx_q) && $stable(base_q) && $stable(sdata_q));

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        done && !fault && ctx_q.op == OP_LOAD && !ctx_q.wide |-> load_data[VEC_W-1:VEC_W/2] == '0);

endmodule

// File: rtl/mvls_unit.sv
module mvls_unit
    import mvls_pkg::*;
#(
    parameter int unsigned VEC_W = 256,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned LANES = dw_lanes(VEC_W),
    localparam int unsigned IDX_W = $clog2(LANES),
    localparam int unsigned MEM_W = QW_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_store,
    input  logic              elem64,
    input  logic              vec256,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [VEC_W-1:0]  mask,
    input  logic [VEC_W-1:0]  store_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [MEM_W-1:0]  mem_wdata,
    output logic              mem_size,
    input  logic              mem_ack,
    input  logic [MEM_W-1:0]  mem_rdata,
    input  logic              mem_fault,
    output logic              done,
    output logic              fault,
    output logic [IDX_W-1:0]  fault_lane,
    output logic [VEC_W-1:0]  load_data
);

    ctx_t             ctx_in;
    logic [LANES-1:0] en_in;
    logic [LANES-1:0] pend;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;

    always_comb begin
        ctx_in.op   = op_e'(op_store);
        ctx_in.es   = esz_e'(elem64);
        ctx_in.wide = vec256;
    end

    mvls_lane_sel #(.VEC_W(VEC_W)) u_sel (
        .mask (mask),
        .ctx  (ctx_in),
        .en   (en_in)
    );

    mvls_lane_pick #(.LANES(LANES)) u_pick (
        .pend  (pend),
        .found (pick_found),
        .idx   (pick_idx)
    );

    mvls_ctrl #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ctx_in     (ctx_in),
        .base_in    (base_addr),
        .en_in      (en_in),
        .sdata_in   (store_data),
        .pick_found (pick_found),
        .pick_idx   (pick_idx),
        .pend       (pend),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_size   (mem_size),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_fault  (mem_fault),
        .done       (done),
        .fault      (fault),
        .fault_lane (fault_lane),
        .load_data  (load_data)
    );

endmodule

// File: tb/mvls_unit_bench.sv
module mvls_unit_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_drv = 1'b0;
    logic         inj_start = 1'b0;
    logic         start;
    logic         op_store = 1'b0, elem64 = 1'b0, vec256 = 1'b0;
    logic [31:0]  base_addr = '0;
    logic [255:0] mask = '0, store_data = '0;
    logic         mem_req, mem_we, mem_size;
    logic [31:0]  mem_addr;
    logic [63:0]  mem_wdata;
    logic         mem_ack = 1'b0, mem_fault = 1'b0;
    logic [63:0]  mem_rdata = '0;
    logic         done, fault;
    logic [2:0]   fault_lane;
    logic [255:0] load_data;

    assign start = start_drv | inj_start;

    always #4 clk = ~clk;

    mvls_unit u_mvls_unit (
        .clk(clk), .rst(rst), .start(start), .op_store(op_store), .elem64(elem64),
        .vec256(vec256), .base_addr(base_addr), .mask(mask), .store_data(store_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_size(mem_size), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_fault(mem_fault),
        .done(done), .fault(fault), .fault_lane(fault_lane), .load_data(load_data)
    );

    int total = 0, fails = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model and request checker
    logic [31:0] mem  [0:255];
    logic [31:0] emem [0:255];
    int          exp_lane [0:7];
    int          exp_n = 0, fault_at = -1, req_seen = 0, extra = 0;
    int          addr_err = 0, data_err = 0, stab_err = 0, wait_cnt = 0;
    bit          cur_es = 0, cur_st = 0, inj_arm = 0;
    logic [31:0] cur_base = '0, first_addr = '0;
    logic [63:0] cur_sdata_w, first_wd = '0;
    logic [255:0] cur_sdata = '0;

    initial begin
        forever begin
            @(negedge clk);
            inj_start = 1'b0;
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_fault = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt == 0) begin
                    first_addr = mem_addr;
                    first_wd = mem_wdata;
                end else if (mem_addr != first_addr || mem_wdata != first_wd) begin
                    stab_err++;
                end
                if (wait_cnt >= (req_seen % 3)) begin
                    int w;
                    wait_cnt = 0;
                    w = int'(mem_addr[9:2]);
                    if (req_seen < exp_n) begin
                        int l;
                        l = exp_lane[req_seen];
                        if (mem_addr != cur_base + (cur_es ? 8 * l : 4 * l) || mem_size != cur_es)
                            addr_err++;
                        cur_sdata_w = cur_es ? cur_sdata[64*l +: 64] : {32'h0, cur_sdata[32*l +: 32]};
                        if (mem_we != cur_st || (cur_st && mem_wdata != cur_sdata_w))
                            data_err++;
                    end else begin
                        extra++;
                    end
                    if (req_seen == fault_at) begin
                        mem_fault = 1'b1;
                        mem_rdata = '1;
                    end else if (mem_we) begin
                        mem[w] = mem_wdata[31:0];
                        if (mem_size) mem[w+1] = mem_wdata[63:32];
                    end else begin
                        mem_rdata = mem_size ? {mem[w+1], mem[w]} : {~mem[w], mem[w]};
                    end
                    if (inj_arm && req_seen == exp_n - 1) begin
                        inj_start = 1'b1;
                        inj_arm = 0;
                    end
                    mem_ack = 1'b1;
                    req_seen++;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    function automatic logic [31:0] init_word(input int w, input int seed);
        return 32'hA500_0000 ^ (32'(w) * 32'h0101_0101) ^ (32'(seed) << 8);
    endfunction

    function automatic int lane_cnt(input bit es, input bit wide);
        return es ? (wide ? 4 : 2) : (wide ? 8 : 4);
    endfunction

    int opn = 0;

    // mode: 0 plain, 1 inject start at last ack, 2 start in done cycle
    task automatic run_op(input bit st, input bit es, input bit wide, input int pat,
                          input int f_at, input int mode);
        int n, t;
        logic [255:0] prev_ld, eld;
        n = lane_cnt(es, wide);
        opn++;
        for (int j = 0; j < 8; j++) mask[32*j +: 32] = $urandom;
        for (int j = 0; j < 8; j++) store_data[32*j +: 32] = $urandom;
        if (es) begin
            for (int j = 0; j < 4; j++) mask[64*j+63] = (j < n) ? pat[j] : 1'b1;
        end else begin
            for (int j = 0; j < 8; j++) mask[32*j+31] = (j < n) ? pat[j] : 1'b1;
        end
        base_addr = 32'h80 + 32'(8 * ($urandom % 4));
        op_store = st; elem64 = es; vec256 = wide;
        exp_n = 0;
        for (int j = 0; j < n; j++) if (pat[j]) begin exp_lane[exp_n] = j; exp_n++; end
        for (int w = 0; w < 256; w++) begin mem[w] = init_word(w, opn); emem[w] = mem[w]; end
        cur_base = base_addr; cur_es = es; cur_st = st; cur_sdata = store_data;
        fault_at = f_at; req_seen = 0; extra = 0; addr_err = 0; data_err = 0; stab_err = 0;
        inj_arm = (mode == 1);
        prev_ld = load_data;
        // expected results
        eld = '0;
        for (int k = 0; k < exp_n; k++) begin
            int l, w;
            if (f_at >= 0 && k >= f_at) break;
            l = exp_lane[k];
            w = int'(base_addr[9:2]) + (es ? 2 * l : l);
            if (st) begin
                emem[w] = store_data[(es ? 64 : 32) * l +: 32];
                if (es) emem[w+1] = store_data[64*l+32 +: 32];
            end else if (es) eld[64*l +: 64] = {emem[w+1], emem[w]};
            else eld[32*l +: 32] = emem[w];
        end
        @(negedge clk); start_drv = 1'b1;
        @(negedge clk); start_drv = 1'b0;
        mask = '1;
        t = 0;
        while (!done && t < 400) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R8 done reached", 256'(done), 256'(1));
        if (f_at >= 0 && f_at < exp_n) begin
            chk(fault == 1'b1, "R7 fault flag", 256'(fault), 256'(1));
            chk(int'(fault_lane) == exp_lane[f_at], "R7 fault lane", 256'(fault_lane), 256'(exp_lane[f_at]));
            chk(req_seen == f_at + 1, "R7 no request after fault", 256'(req_seen), 256'(f_at + 1));
            chk(load_data == prev_ld, "R9 load_data kept on fault", load_data, prev_ld);
        end else begin
            chk(fault == 1'b0, exp_n == 0 ? "R6 no fault on empty mask" : "R7 no fault", 256'(fault), 256'(0));
            chk(req_seen == exp_n, exp_n == 0 ? "R6 no request" : "R1 request count", 256'(req_seen), 256'(exp_n));
            if (!st) chk(load_data == eld, "R3 load result", load_data, eld);
            else chk(load_data == prev_ld, "R9 store keeps load_data", load_data, prev_ld);
        end
        chk(addr_err == 0, "R2 R5 address and order", 256'(addr_err), 256'(0));
        chk(data_err == 0, "R4 write enable and data", 256'(data_err), 256'(0));
        chk(stab_err == 0, "R5 request held stable", 256'(stab_err), 256'(0));
        if (st) begin
            int bad;
            bad = 0;
            for (int w = 0; w < 256; w++) if (mem[w] != emem[w]) bad++;
            chk(bad == 0, "R4 memory image", 256'(bad), 256'(0));
        end
        if (mode == 2) begin
            start_drv = 1'b1;
            @(negedge clk); start_drv = 1'b0;
            t = 0;
            while (!done && t < 400) begin @(negedge clk); t++; end
            chk(extra == n, "R8 start in done cycle accepted", 256'(extra), 256'(n));
            @(negedge clk);
        end else begin
            bit seen;
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", 256'(done), 256'(0));
            seen = 0;
            for (int k = 0; k < 4; k++) begin @(negedge clk); if (mem_req || done) seen = 1; end
            chk(seen == 0 && extra == 0, "R8 busy start ignored", 256'(extra), 256'(0));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc == 150000) begin
                total++; fails++;
                $display("FAIL R8 watchdog actual=%0d expected=done", cyc);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !fault && !mem_req && load_data == '0, "R9 reset state",
            {load_data[252:0], done, fault, mem_req}, 256'(0));
        // R1 R3 R4: sweep every enable pattern for every shape and direction
        for (int st = 0; st < 2; st++)
            for (int es = 0; es < 2; es++)
                for (int wd = 0; wd < 2; wd++) begin
                    int n;
                    n = lane_cnt(es[0], wd[0]);
                    for (int p = 0; p < (1 << n); p++) run_op(st[0], es[0], wd[0], p, -1, 0);
                end
        // R7: fault on each enabled position of an all-ones mask
        for (int st = 0; st < 2; st++)
            for (int es = 0; es < 2; es++)
                for (int wd = 0; wd < 2; wd++) begin
                    int n;
                    n = lane_cnt(es[0], wd[0]);
                    for (int f = 0; f < n; f++) run_op(st[0], es[0], wd[0], (1 << n) - 1, f, 0);
                end
        // R7 with sparse mask: fault on the second enabled lane
        run_op(1'b0, 1'b0, 1'b1, 8'b1010_0100, 1, 0);
        // R8: start during last acknowledge, and start in the done cycle
        run_op(1'b0, 1'b0, 1'b1, 8'b0110_1001, -1, 1);
        run_op(1'b1, 1'b1, 1'b1, 4'b1011, -1, 1);
        run_op(1'b0, 1'b1, 1'b0, 2'b10, -1, 2);
        run_op(1'b1, 1'b0, 1'b0, 4'b0101, -1, 2);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule